// File: doc/BRIEF.md
# Repeated-Count SIMD Pixel ALU

This execution unit sits beside a coprocessor's register file and turns one command into a burst of per-element operations. A command names a start register for each of two source ranges and for the destination range, an operation, and a repeat count. The unit then walks the three ranges together and handles one element per clock. In each cycle it presents two read addresses, combines the returned 32-bit words, and issues one register write.

Each 32-bit word holds four 8-bit colour channels. The unit supports four operations:

- a lane-wise add;
- a lane-wise multiply that divides by 255 with rounding, for alpha blending;
- any of the sixteen X11 logical functions applied between a source and the current destination contents;
- a mask-driven select between two fixed colour registers, which expands monochrome glyph bits into colour pixels.

The register file is outside the block. Its read ports are combinational, and the write happens on the clock edge that ends each element's cycle.

Top module: `pixel_burst_alu`

## Requirements
- R1: With `busy` low, a high `cmdValid` at a clock edge starts a command, and `busy` is high in the next cycle.
- R2: A command processes `cmdCount`+1 elements (1 to 16), one per cycle on consecutive cycles. `wrEn` is high in each of these cycles, and `wrAddr` runs `cmdDst`, `cmdDst`+1, and so on.
- R3: `busy` stays high through the cycle of the last element's write. `done` is high for exactly the next single cycle and is never high while `busy` is high.
- R4: `cmdValid` has no effect while `busy` is high. The running command's writes, its element count and all register contents are as if no second command had been offered.
- R5: Op code 0 (add) writes, in each 8-bit lane, (A + B) modulo 256, with no carry between lanes.
- R6: Op code 1 (multiply) writes, in each lane, the value (t + (t >> 8)) >> 8, where t = A*B + 128 and all intermediates fit in 16 bits. For example, 255*255 gives 255 and 128*128 gives 64.
- R7: Op code 2 (logic function) reads the destination register on port B and writes f(src, dst) bit by bit, where result bit = `cmdRop`[{~src, ~dst}]. Examples of this encoding: 0 clear, 1 and, 3 copy, 5 keep dst, 6 xor, 15 set.
- R8: Op code 3 (select) reads the same two registers, `cmdSrcA` and `cmdSrcB`, for every element. Element i writes A if `cmdMask`[i] is 1 and B if it is 0, and bit 0 belongs to the first element.
- R9: For ops 0 to 2, both read addresses advance by one per element. All register indices wrap modulo the register count (128).
- R10: After reset, `busy`, `done` and `wrEn` are low, and `wrEn` stays low whenever no command is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered this cycle |
| cmdOp | input | 2 | Operation: 0 add, 1 multiply, 2 logic function, 3 select |
| cmdRop | input | 4 | Logic-function truth table |
| cmdSrcA | input | 7 | First source start register |
| cmdSrcB | input | 7 | Second source start register |
| cmdDst | input | 7 | Destination start register |
| cmdCount | input | 4 | Element count minus one |
| cmdMask | input | 16 | Select mask, one bit per element |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdAddrA | output | 7 | Read address, port A |
| rdAddrB | output | 7 | Read address, port B (destination for op 2) |
| rdDataA | input | 32 | Read data, port A |
| rdDataB | input | 32 | Read data, port B |
| wrEn | output | 1 | Register write strobe |
| wrAddr | output | 7 | Register write address |
| wrData | output | 32 | Register write data |

## Verification
The assertions check the following on every cycle:
- how the sequencer behaves: a start raises `busy`, the element counter advances while `busy` is high whatever `cmdValid` does, and `done` is a single cycle that follows `busy`;
- that the destination address steps by exactly one per element;
- that the select operation's read addresses stay fixed.

The lane arithmetic cannot be shown that way. This covers rounding in the multiply, lane isolation in the add, and the truth-table encoding of the logic function. The same holds for register ranges that overlap or wrap at the top of the file, and for a second command offered mid-burst. Only the bench's directed and random commands, compared against a sequential reference model of the register file, demonstrate these.

// File: rtl/pixel_burst_pkg.sv
package pixel_burst_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_MUL = 2'd1,
    OP_ROP = 2'd2,
    OP_SEL = 2'd3
  } burst_op_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture a new command
    logic step;   // one element is processed this cycle
  } seq_strobe_t;

endpackage

// File: rtl/pixel_lane.sv
module pixel_lane
  import pixel_burst_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic [1:0]        op,
  input  logic [3:0]        rop,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  output logic [LANE_W-1:0] y
);
  localparam int PROD_W = 2 * LANE_W;
  localparam logic [PROD_W-1:0] HALF = PROD_W'(1) << (LANE_W - 1);

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] biased;
  logic [PROD_W-1:0] folded;
  logic [LANE_W-1:0] ropOut;

  always_comb begin
    prod   = PROD_W'(a) * PROD_W'(b);
    biased = prod + HALF;
    folded = biased + (biased >> LANE_W);
    ropOut = ({LANE_W{rop[0]}} &  a &  b) |
             ({LANE_W{rop[1]}} &  a & ~b) |
             ({LANE_W{rop[2]}} & ~a &  b) |
             ({LANE_W{rop[3]}} & ~a & ~b);
    case (op)
      OP_ADD:  y = a + b;
      OP_MUL:  y = folded[PROD_W-1:LANE_W];
      OP_ROP:  y = ropOut;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/pixel_burst_ctrl.sv
module pixel_burst_ctrl
  import pixel_burst_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [CNT_W-1:0] cmdCount,
  output seq_strobe_t      strobe,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] elemIdx;
  logic [CNT_W-1:0] lastIdx;
  logic             lastElem;

  assign lastElem     = (elemIdx == lastIdx);
  assign strobe.load  = cmdValid && !busy;
  assign strobe.step  = busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      elemIdx <= '0;
      lastIdx <= '0;
    end else begin
      done <= 1'b0;
      if (strobe.load) begin
        busy    <= 1'b1;
        elemIdx <= '0;
        lastIdx <= cmdCount;
      end else if (busy) begin
        if (lastElem) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          elemIdx <= elemIdx + 1'b1;
        end
      end
    end
  end

  // R1: an accepted command raises busy
  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy) |=> busy);

  // R4: while running, the element counter advances regardless of cmdValid
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastElem) |=> (busy && elemIdx == $past(elemIdx) + 1'b1));

  // R3: done is a single cycle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: done follows the final busy cycle and never overlaps busy
  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/pixel_burst_datapath.sv
module pixel_burst_datapath
  import pixel_burst_pkg::*;
#(
  parameter int REG_AW = 7,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seq_strobe_t             strobe,
  input  logic [1:0]              cmdOp,
  input  logic [3:0]              cmdRop,
  input  logic [REG_AW-1:0]       cmdSrcA,
  input  logic [REG_AW-1:0]       cmdSrcB,
  input  logic [REG_AW-1:0]       cmdDst,
  input  logic [(1<<CNT_W)-1:0]   cmdMask,
  output logic [REG_AW-1:0]       rdAddrA,
  output logic [REG_AW-1:0]       rdAddrB,
  input  logic [LANES*LANE_W-1:0] rdDataA,
  input  logic [LANES*LANE_W-1:0] rdDataB,
  output logic                    wrEn,
  output logic [REG_AW-1:0]       wrAddr,
  output logic [LANES*LANE_W-1:0] wrData
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int MASK_W = 1 << CNT_W;

  burst_op_e         opQ;
  logic [3:0]        ropQ;
  logic [REG_AW-1:0] aPtr, bPtr, dPtr;
  logic [MASK_W-1:0] maskQ;
  logic [DATA_W-1:0] laneOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ   <= OP_ADD;
      ropQ  <= '0;
      aPtr  <= '0;
      bPtr  <= '0;
      dPtr  <= '0;
      maskQ <= '0;
    end else if (strobe.load) begin
      opQ   <= burst_op_e'(cmdOp);
      ropQ  <= cmdRop;
      aPtr  <= cmdSrcA;
      bPtr  <= cmdSrcB;
      dPtr  <= cmdDst;
      maskQ <= cmdMask;
    end else if (strobe.step) begin
      dPtr  <= dPtr + 1'b1;
      maskQ <= maskQ >> 1;
      if (opQ != OP_SEL) begin
        aPtr <= aPtr + 1'b1;
        bPtr <= bPtr + 1'b1;
      end
    end
  end

  assign rdAddrA = aPtr;
  assign rdAddrB = (opQ == OP_ROP) ? dPtr : bPtr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pixel_lane #(.LANE_W(LANE_W)) u_lane (
      .op  (opQ),
      .rop (ropQ),
      .a   (rdDataA[g*LANE_W +: LANE_W]),
      .b   (rdDataB[g*LANE_W +: LANE_W]),
      .y   (laneOut[g*LANE_W +: LANE_W])
    );
  end

  assign wrEn   = strobe.step;
  assign wrAddr = dPtr;
  assign wrData = (opQ == OP_SEL) ? (maskQ[0] ? rdDataA : rdDataB) : laneOut;

  // R2: destination advances by exactly one per element
  p_dst_advance_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && $past(strobe.step)) |-> ((wrAddr - $past(wrAddr)) == REG_AW'(1)));

  // R8: select keeps both colour registers fixed over the burst
  p_sel_fixed_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && $past(strobe.step) && opQ == OP_SEL) |->
      (rdAddrA == $past(rdAddrA) && rdAddrB == $past(rdAddrB)));

  // R9: arithmetic ops walk the source range
  p_src_advance_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && $past(strobe.step) && opQ != OP_SEL && opQ != OP_ROP) |->
      ((rdAddrA - $past(rdAddrA)) == REG_AW'(1)));
endmodule

// File: rtl/pixel_burst_alu.sv
module pixel_burst_alu
  import pixel_burst_pkg::*;
#(
  parameter int REG_AW = 7,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmdValid,
  input  logic [1:0]              cmdOp,
  input  logic [3:0]              cmdRop,
  input  logic [REG_AW-1:0]       cmdSrcA,
  input  logic [REG_AW-1:0]       cmdSrcB,
  input  logic [REG_AW-1:0]       cmdDst,
  input  logic [CNT_W-1:0]        cmdCount,
  input  logic [(1<<CNT_W)-1:0]   cmdMask,
  output logic                    busy,
  output logic                    done,
  output logic [REG_AW-1:0]       rdAddrA,
  output logic [REG_AW-1:0]       rdAddrB,
  input  logic [LANES*LANE_W-1:0] rdDataA,
  input  logic [LANES*LANE_W-1:0] rdDataB,
  output logic                    wrEn,
  output logic [REG_AW-1:0]       wrAddr,
  output logic [LANES*LANE_W-1:0] wrData
);
  seq_strobe_t strobe;

  pixel_burst_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdCount (cmdCount),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  pixel_burst_datapath #(
    .REG_AW(REG_AW), .LANES(LANES), .LANE_W(LANE_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cmdOp   (cmdOp),
    .cmdRop  (cmdRop),
    .cmdSrcA (cmdSrcA),
    .cmdSrcB (cmdSrcB),
    .cmdDst  (cmdDst),
    .cmdMask (cmdMask),
    .rdAddrA (rdAddrA),
    .rdAddrB (rdAddrB),
    .rdDataA (rdDataA),
    .rdDataB (rdDataB),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData)
  );

  // R10: no register write while idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy) |-> (!wrEn));
endmodule

// File: tb/pixel_burst_alu_test.sv
module pixel_burst_alu_test;
  localparam int AW   = 7;
  localparam int NREG = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN;
  logic cmdValid;
  logic [1:0] cmdOp;
  logic [3:0] cmdRop;
  logic [AW-1:0] cmdSrcA, cmdSrcB, cmdDst;
  logic [3:0] cmdCount;
  logic [15:0] cmdMask;
  logic busy, done, wrEn;
  logic [AW-1:0] rdAddrA, rdAddrB, wrAddr;
  logic [31:0] rdDataA, rdDataB, wrData;

  logic [31:0] rf [NREG];
  logic [31:0] refRf [NREG];
  logic tbLd;
  logic [AW-1:0] tbLdAddr;
  logic [31:0] tbLdData;

  int testsRun = 0;
  int testsFail = 0;
  int cycles = 0;
  bit finished = 0;

  pixel_burst_alu uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdRop(cmdRop),
    .cmdSrcA(cmdSrcA), .cmdSrcB(cmdSrcB), .cmdDst(cmdDst), .cmdCount(cmdCount),
    .cmdMask(cmdMask), .busy(busy), .done(done), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  assign rdDataA = rf[rdAddrA];
  assign rdDataB = rf[rdAddrB];

  always @(posedge clk) begin
    if (wrEn) rf[wrAddr] <= wrData;
    else if (tbLd) rf[tbLdAddr] <= tbLdData;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Reference arithmetic, written from the requirements
  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    int t;
    t = int'(a) * int'(b) + 128;
    return 8'((t + (t / 256)) / 256);
  endfunction

  function automatic logic [31:0] ref_elem(input logic [1:0] op, input logic [3:0] rop,
                                           input logic [31:0] s, input logic [31:0] d,
                                           input bit m);
    logic [31:0] r;
    r = '0;
    case (op)
      2'd0: for (int l = 0; l < 4; l++) r[l*8 +: 8] = s[l*8 +: 8] + d[l*8 +: 8];
      2'd1: for (int l = 0; l < 4; l++) r[l*8 +: 8] = ref_mul(s[l*8 +: 8], d[l*8 +: 8]);
      2'd2: for (int j = 0; j < 32; j++) r[j] = rop[{~s[j], ~d[j]}];
      default: r = m ? s : d;
    endcase
    return r;
  endfunction

  function automatic string op_tag(input logic [1:0] op);
    case (op)
      2'd0: return "R5";
      2'd1: return "R6";
      2'd2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic poke(input logic [AW-1:0] addr, input logic [31:0] data);
    tbLd = 1'b1; tbLdAddr = addr; tbLdData = data;
    @(negedge clk);
    tbLd = 1'b0;
    refRf[addr] = data;
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [3:0] rop,
                         input logic [AW-1:0] a, input logic [AW-1:0] b,
                         input logic [AW-1:0] d, input logic [3:0] cnt,
                         input logic [15:0] mask, input bit inject);
    logic [31:0] expD [16];
    int writes;
    bit gotDone;
    bit injected;
    for (int e = 0; e <= int'(cnt); e++) begin
      logic [AW-1:0] aa, bb, dd;
      logic [31:0] sa, sb;
      aa = (op == 2'd3) ? a : AW'(a + e);
      bb = (op == 2'd3) ? b : AW'(b + e);
      dd = AW'(d + e);
      sa = refRf[aa];
      sb = (op == 2'd2) ? refRf[dd] : refRf[bb];
      expD[e] = ref_elem(op, rop, sa, sb, mask[e]);
      refRf[dd] = expD[e];
    end
    cmdValid = 1'b1; cmdOp = op; cmdRop = rop; cmdSrcA = a; cmdSrcB = b;
    cmdDst = d; cmdCount = cnt; cmdMask = mask;
    @(negedge clk);
    cmdValid = 1'b0;
    check(busy === 1'b1, "R1", "busy after start", 32'(busy), 32'd1);
    writes = 0; gotDone = 0; injected = 0;
    for (int c = 0; c < 40 && !gotDone; c++) begin
      cmdValid = 1'b0;
      if (done) begin
        gotDone = 1;
        check(busy === 1'b0 && wrEn === 1'b0, "R3", "busy/wrEn low at done",
              {30'd0, busy, wrEn}, 32'd0);
      end else begin
        if (wrEn) begin
          if (writes < 16) begin
            check(wrAddr === AW'(d + writes), "R2", "write address",
                  32'(wrAddr), 32'(AW'(d + writes)));
            check(wrData === expD[writes], op_tag(op), "element result",
                  wrData, expD[writes]);
          end
          writes++;
        end
        if (inject && writes == 1 && !injected) begin
          // R4: offer a different command mid-burst
          cmdValid = 1'b1; cmdOp = ~op; cmdRop = ~rop; cmdSrcA = d; cmdSrcB = a;
          cmdDst = AW'(d + 40); cmdCount = 4'd15; cmdMask = ~mask;
          injected = 1;
        end
        @(negedge clk);
      end
    end
    cmdValid = 1'b0;
    check(gotDone, "R3", "done seen", 32'(gotDone), 32'd1);
    check(writes == int'(cnt) + 1, inject ? "R4" : "R2", "element count",
          32'(writes), 32'(int'(cnt) + 1));
    @(negedge clk);
    check(done === 1'b0, "R3", "done lasts one cycle", 32'(done), 32'd0);
    begin
      int bad;
      bad = 0;
      for (int r = 0; r < NREG; r++) if (rf[r] !== refRf[r]) bad++;
      check(bad == 0, inject ? "R4" : "R9", "register file contents", 32'(bad), 32'd0);
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      testsRun++; testsFail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'd20240611);
    rstN = 1'b0; cmdValid = 1'b0; cmdOp = '0; cmdRop = '0; cmdSrcA = '0;
    cmdSrcB = '0; cmdDst = '0; cmdCount = '0; cmdMask = '0;
    tbLd = 1'b0; tbLdAddr = '0; tbLdData = '0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && wrEn === 1'b0, "R10", "reset state",
          {29'd0, busy, done, wrEn}, 32'd0);
    rstN = 1'b1;
    for (int r = 0; r < NREG; r++) poke(AW'(r), $urandom);
    check(wrEn === 1'b0 && busy === 1'b0, "R10", "idle no write", 32'(wrEn), 32'd0);

    // R5: lane isolation and wrap
    poke(7'd10, 32'h01FF_8010); poke(7'd20, 32'h0101_8001);
    run_cmd(2'd0, 4'd0, 7'd10, 7'd20, 7'd30, 4'd0, 16'h0, 0);
    check(rf[30] === 32'h0200_0011, "R5", "lane add wrap", rf[30], 32'h0200_0011);

    // R6: rounding corners
    poke(7'd11, 32'hFF00_80FF); poke(7'd21, 32'hFFFF_8001);
    run_cmd(2'd1, 4'd0, 7'd11, 7'd21, 7'd31, 4'd0, 16'h0, 0);
    check(rf[31] === 32'hFF00_4001, "R6", "multiply corners", rf[31], 32'hFF00_4001);

    // R7: xor and keep-dst
    poke(7'd12, 32'h0000_F0F0); poke(7'd32, 32'h0000_FF00);
    run_cmd(2'd2, 4'd6, 7'd12, 7'd0, 7'd32, 4'd0, 16'h0, 0);
    check(rf[32] === 32'h0000_0FF0, "R7", "xor", rf[32], 32'h0000_0FF0);
    run_cmd(2'd2, 4'd5, 7'd12, 7'd0, 7'd32, 4'd0, 16'h0, 0);
    check(rf[32] === 32'h0000_0FF0, "R7", "keep dst", rf[32], 32'h0000_0FF0);

    // R8: glyph expansion, bit 0 first
    poke(7'd1, 32'hAAAA_AAAA); poke(7'd2, 32'h5555_5555);
    run_cmd(2'd3, 4'd0, 7'd1, 7'd2, 7'd50, 4'd2, 16'h0005, 0);
    check(rf[50] === 32'hAAAA_AAAA && rf[51] === 32'h5555_5555 && rf[52] === 32'hAAAA_AAAA,
          "R8", "mask order", rf[51], 32'h5555_5555);

    // R9: wrap at top of register file, full 16-element burst
    run_cmd(2'd0, 4'd0, 7'd120, 7'd60, 7'd126, 4'd15, 16'h0, 0);
    // R4: command offered while busy
    run_cmd(2'd1, 4'd0, 7'd70, 7'd80, 7'd90, 4'd5, 16'h0, 1);

    for (int t = 0; t < 60; t++) begin
      run_cmd(2'($urandom), 4'($urandom), AW'($urandom), AW'($urandom), AW'($urandom),
              4'($urandom), 16'($urandom), ($urandom % 4) == 0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end
endmodule